// File: doc/BRIEF.md
# Byte-Lane Static RAM Strobe Sequencer

This block lets a synchronous host reach an external asynchronous static RAM. The RAM has a 16-bit shared data bus split into two byte lanes, and each lane has its own active-low enable. The host side uses a valid/ready request channel that carries address, write data, a two-bit lane mask and a direction flag. Read results come back on a data bus with a one-clock valid strobe. On the memory side the block drives the address, chip select, write strobe, output enable, the two lane enables, and a data bus split into output value, driver enable and input value.

Every memory timing interval is a whole number of system clocks, and each is set by a parameter: address setup before the write strobe, write strobe width, recovery after the strobe, and read access time. The block holds output enable high for the whole write sequence. It turns its data drivers on only once the write strobe is already low, and turns them off one clock after the strobe rises. As a result it never drives the bus while the memory could be driving it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both lane enables are high, the data driver enable is low, request ready is high and the response strobe is low.
- R2: During an access, the lower lane enable is low exactly when mask bit 0 is set, and the upper lane enable is low exactly when mask bit 1 is set. A read with mask 2'b00 enables both lanes.
- R3: A write holds chip select low and the write strobe high for T_SETUP clocks. It then holds the write strobe low for T_PULSE clocks (T_PULSE of at least 2). It then keeps chip select low with the strobe high for T_RECOV clocks.
- R4: Output enable stays high throughout a write. The data driver enable is never high while output enable is low.
- R5: The data driver enable goes high in the second clock of the write strobe. It stays high until one clock after the strobe rises. While it is high, the bus output equals the request's write data.
- R6: A read holds chip select and output enable low, with the write strobe high, for T_ACCESS clocks. In the next clock the response strobe is high for exactly one cycle, carrying the bus value sampled at the end of that window.
- R7: In read data, the byte of any lane whose enable was high during the read is zero.
- R8: A write changes only the memory lanes whose mask bits are set. A write with mask 2'b00 changes nothing.
- R9: Request ready is high only while no access is in progress. A request held valid while the block is busy is accepted only once ready returns.
- R10: The memory address equals the accepted request address and is stable for every clock that chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-clock read result strobe |
| rsp_rdata | output | 16 | Read result |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
Two events share a clock edge at the end of a write pulse: the write strobe rises in the same cycle in which the drivers must still hold data for the hold time. A second pair shares the clock after a read: the response strobe appears in the same cycle in which ready returns, so a new request can be accepted there. The bench provokes both by keeping a request valid across a write followed by two reads. It judges the first pair by cycle position, requiring the driver enable exactly in the first recovery clock and off afterwards. It judges the second pair by requiring ready high in the response cycle and both read results to match the reference memory.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV,
        ST_RACCESS
    } phase_e;
endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one bus phase; done while the count is zero.
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
// Host mask to active-low lane enables; an empty read mask selects every lane.
module sram_lane_decode #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] mask,
    input  logic             is_read,
    output logic [LANES-1:0] lane_n
);
    logic all_lanes;
    assign all_lanes = is_read && (mask == '0);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ~(mask[i] | all_lanes);
    end
endmodule

// File: rtl/sram_lane_merge.sv
// Zeroes the byte of every lane that was not enabled during a read.
module sram_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] raw,
    input  logic [LANES-1:0]        lane_n,
    output logic [LANES*LANE_W-1:0] data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data[i*LANE_W +: LANE_W] =
            lane_n[i] ? '0 : raw[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW       = 10,
    parameter int T_SETUP  = 1,   // clocks of address setup before strobe
    parameter int T_PULSE  = 2,   // strobe width, must be at least 2
    parameter int T_RECOV  = 1,   // clocks held after strobe rises
    parameter int T_ACCESS = 2    // read access clocks
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    output logic                    rsp_valid,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic [AW-1:0]           mem_addr,
    output logic                    mem_cs_n,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic                    mem_lb_n,
    output logic                    mem_ub_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);
    localparam int DW   = LANES * LANE_W;
    localparam int M1   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int M2   = (T_RECOV > T_ACCESS) ? T_RECOV : T_ACCESS;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] lane_n;
        logic             cs_n;
        logic             we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [DW-1:0]    rdata;
        logic             rsp_valid;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        phase: ST_IDLE, addr: '0, wdata: '0, lane_n: '1,
        cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0,
        rdata: '0, rsp_valid: 1'b0
    };

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_done;
    logic [LANES-1:0] req_lane_n;
    logic [DW-1:0]    rd_merged;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_decode #(.LANES(LANES)) u_decode (
        .mask    (req_mask),
        .is_read (~req_write),
        .lane_n  (req_lane_n)
    );

    sram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .raw    (mem_dq_in),
        .lane_n (ctl_q.lane_n),
        .data   (rd_merged)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        tmr_load        = 1'b0;
        tmr_val         = '0;
        unique case (ctl_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr   = req_addr;
                    ctl_d.wdata  = req_wdata;
                    ctl_d.lane_n = req_lane_n;
                    ctl_d.cs_n   = 1'b0;
                    ctl_d.we_n   = 1'b1;
                    tmr_load     = 1'b1;
                    if (req_write) begin
                        ctl_d.oe_n  = 1'b1;
                        ctl_d.phase = ST_WSETUP;
                        tmr_val     = CW'(T_SETUP - 1);
                    end else begin
                        ctl_d.oe_n  = 1'b0;
                        ctl_d.phase = ST_RACCESS;
                        tmr_val     = CW'(T_ACCESS - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_done) begin
                    ctl_d.we_n  = 1'b0;
                    ctl_d.phase = ST_WPULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(T_PULSE - 1);
                end
            end
            ST_WPULSE: begin
                // strobe is already low here, so drivers may turn on next clock
                ctl_d.dq_oe = 1'b1;
                if (tmr_done) begin
                    ctl_d.we_n  = 1'b1;
                    ctl_d.phase = ST_WRECOV;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(T_RECOV - 1);
                end
            end
            ST_WRECOV: begin
                ctl_d.dq_oe = 1'b0;
                if (tmr_done) begin
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.lane_n = '1;
                    ctl_d.phase  = ST_IDLE;
                end
            end
            ST_RACCESS: begin
                if (tmr_done) begin
                    ctl_d.rdata     = rd_merged;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.cs_n      = 1'b1;
                    ctl_d.oe_n      = 1'b1;
                    ctl_d.lane_n    = '1;
                    ctl_d.phase     = ST_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign req_ready  = (ctl_q.phase == ST_IDLE);
    assign rsp_valid  = ctl_q.rsp_valid;
    assign rsp_rdata  = ctl_q.rdata;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_lb_n   = ctl_q.lane_n[0];
    assign mem_ub_n   = ctl_q.lane_n[1];
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe
);
    a_r4_no_drive_into_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r5_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    a_r5_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW       = 6;
    localparam int T_SETUP  = 2;
    localparam int T_PULSE  = 3;
    localparam int T_RECOV  = 2;
    localparam int T_ACCESS = 3;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [15:0] data;
        logic [1:0]  mask;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd3,  16'hBEEF, 2'b11},
        '{1'b0, 6'd3,  16'h0000, 2'b11},
        '{1'b1, 6'd7,  16'h1234, 2'b01},
        '{1'b0, 6'd7,  16'h0000, 2'b00},
        '{1'b1, 6'd7,  16'hAB00, 2'b10},
        '{1'b0, 6'd7,  16'h0000, 2'b11},
        '{1'b0, 6'd3,  16'h0000, 2'b01},
        '{1'b0, 6'd3,  16'h0000, 2'b10},
        '{1'b1, 6'd63, 16'hF00D, 2'b11},
        '{1'b0, 6'd63, 16'h0000, 2'b10},
        '{1'b1, 6'd0,  16'h5555, 2'b01},
        '{1'b0, 6'd0,  16'h0000, 2'b00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0]   mem_dq_out;
    logic          mem_dq_oe;
    logic [15:0]   mem_dq_in;

    logic [15:0] mem     [64];
    logic [15:0] ref_mem [64];
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_ctrl #(
        .AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
        .T_RECOV(T_RECOV), .T_ACCESS(T_ACCESS)
    ) i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: lanes disabled or a deselected bus return noise.
    always_comb begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_ub_n ? 8'hA5 : mem[mem_addr][15:8],
                         mem_lb_n ? 8'h5A : mem[mem_addr][7:0]};
        else
            mem_dq_in = 16'hDEAD;
    end

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) mem[mem_addr][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr][15:8] <= mem_dq_out[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [5:0] a, input logic [1:0] m);
        logic [1:0] e;
        e = (m == 2'b00) ? 2'b11 : m;
        return {e[1] ? ref_mem[a][15:8] : 8'h00, e[0] ? ref_mem[a][7:0] : 8'h00};
    endfunction

    task automatic ref_write(input logic [5:0] a, input logic [15:0] d, input logic [1:0] m);
        if (m[0]) ref_mem[a][7:0]  = d[7:0];
        if (m[1]) ref_mem[a][15:8] = d[15:8];
    endtask

    // One request with a per-cycle monitor of the memory side.
    task automatic run_op(input logic wr, input logic [5:0] a, input logic [15:0] dat,
                          input logic [1:0] m);
        int setup = 0, pulse = 0, recov = 0, oelow = 0, cyc = 0;
        int drive_bad = 0, busy_ready = 0, lane_bad = 0, addr_bad = 0, clash = 0;
        logic [1:0]  me;
        logic [15:0] exp;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready while idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        me = (!wr && m == 2'b00) ? 2'b00 : ~m;
        while (mem_cs_n == 1'b0 && cyc < 64) begin
            cyc++;
            if (req_ready) busy_ready++;
            if (mem_addr !== a) addr_bad++;
            if ({mem_ub_n, mem_lb_n} !== me) lane_bad++;
            if (!mem_oe_n) oelow++;
            if (mem_dq_oe && !mem_oe_n) clash++;
            if (wr) begin
                if (!mem_we_n) begin
                    pulse++;
                    if (mem_dq_oe !== (pulse > 1)) drive_bad++;
                end else if (pulse == 0) begin
                    setup++;
                    if (mem_dq_oe) drive_bad++;
                end else begin
                    recov++;
                    if (mem_dq_oe !== (recov == 1)) drive_bad++;
                end
                if (mem_dq_oe && mem_dq_out !== dat) drive_bad++;
            end else if (!mem_we_n || mem_dq_oe) begin
                drive_bad++;
            end
            @(negedge clk);
        end
        check(busy_ready == 0, "R9 ready low while busy", 32'(busy_ready), 0);
        check(addr_bad == 0, "R10 address held", 32'(addr_bad), 0);
        check(lane_bad == 0, "R2 lane enables", 32'(lane_bad), 0);
        check(clash == 0, "R4 no drive with output enable low", 32'(clash), 0);
        check(drive_bad == 0, "R5 driver window and data", 32'(drive_bad), 0);
        if (wr) begin
            check(setup == T_SETUP, "R3 setup clocks", 32'(setup), T_SETUP);
            check(pulse == T_PULSE, "R3 strobe clocks", 32'(pulse), T_PULSE);
            check(recov == T_RECOV, "R3 recovery clocks", 32'(recov), T_RECOV);
            check(oelow == 0, "R4 output enable high in write", 32'(oelow), 0);
            ref_write(a, dat, m);
        end else begin
            exp = exp_read(a, m);
            check(oelow == T_ACCESS, "R6 access clocks", 32'(oelow), T_ACCESS);
            check(rsp_valid === 1'b1, "R6 response strobe", 32'(rsp_valid), 1);
            check(rsp_rdata === exp, "R7 read data lanes", 32'(rsp_rdata), 32'(exp));
            @(negedge clk);
            check(rsp_valid === 1'b0, "R6 strobe one clock", 32'(rsp_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 16'(i * 16'h0301) ^ 16'hC3A0;
            ref_mem[i] = 16'(i * 16'h0301) ^ 16'hC3A0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} === 5'b11111,
              "R1 memory controls high", 32'({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1f);
        check(mem_dq_oe === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b1,
              "R1 driver, strobe, ready", 32'({mem_dq_oe, rsp_valid, req_ready}), 32'b001);
        rst_n = 1'b1;

        foreach (VECS[k]) run_op(VECS[k].wr, VECS[k].addr, VECS[k].data, VECS[k].mask);

        // R8: a write with an empty mask leaves the word unchanged
        run_op(1'b1, 6'd9, 16'hFFFF, 2'b00);
        run_op(1'b0, 6'd9, 16'h0000, 2'b11);
        check(mem[9] === ref_mem[9], "R8 empty-mask write", 32'(mem[9]), 32'(ref_mem[9]));
        // R8: lane-only write seen through a full read
        run_op(1'b1, 6'd20, 16'h77CC, 2'b10);
        run_op(1'b0, 6'd20, 16'h0000, 2'b11);

        // R9 + R6: request held valid across write, read, read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd30; req_wdata = 16'h9A3C; req_mask = 2'b11;
        @(negedge clk);
        ref_write(6'd30, 16'h9A3C, 2'b11);
        req_write = 1'b0; req_mask = 2'b11;
        for (int n = 0; n < 2; n++) begin
            int w = 0;
            while (!rsp_valid && w < 64) begin
                w++;
                @(negedge clk);
            end
            check(rsp_rdata === ref_mem[req_addr], "R9 held request served",
                  32'(rsp_rdata), 32'(ref_mem[req_addr]));
            check(req_ready === 1'b1, "R6 ready in response cycle", 32'(req_ready), 1);
            if (n == 0) req_addr = 6'd31;
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
        end
        repeat (T_ACCESS + 3) @(negedge clk);
        check(mem_cs_n === 1'b1, "R9 idle after last request", 32'(mem_cs_n), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule